// File: doc/BRIEF.md
# Cipher Key Register Bank

This block stores the two 128-bit keys of a stream-cipher engine that both encrypts and authenticates: a confidentiality key and an integrity key. A host loads the keys through a 64-bit register bus, and the block drives both keys continuously into the cipher datapath. The key slots can only be written. Any attempt to read them, any touch of an unmapped word in the block's window, a key write made while the engine is running, and an inconsistent mode setting each set a sticky bit in an interrupt status register. The host clears these bits by writing ones to that register.

In authentication-only mode, the two low key slots load the integrity key instead of the confidentiality key, so the host can use the same offsets for either job. A small sequencer streams the engine's saved context out as nine 64-bit words. It follows a fixed order, moves one word per accepted handshake, and marks the final word.

Top module: `cipher_key_bank`

## Requirements
- R1: After synchronous reset, both key outputs, the mode output and the status register are zero, `irq` is low and `unload_valid` is low.
- R2: A write at window offset 0x00 or 0x08 loads confidentiality-key bits 127:64 (bytes 1–8) or 63:0 (bytes 9–16). A write at 0x10 or 0x18 loads the integrity key in the same way. Each key output shows the new value from the cycle after the write.
- R3: A read of any key slot returns `bus_rvalid` one cycle later with `bus_rdata` all zero, and it sets status bit 0 (address error).
- R4: A key write in a cycle where `engine_busy` is high is dropped, and it sets status bit 1 (context error). This includes the cycle in which busy first rises. Both keys keep their values.
- R5: When mode bit 0 (authentication only) is set, writes at 0x00 and 0x08 load integrity-key bits 127:64 and 63:0. The confidentiality key is left unchanged.
- R6: A read or write at any other word offset in the 256-byte window (0x30–0xF8), or at an offset that is not 8-byte aligned, sets status bit 0. An access outside the window at base 0x3E400 has no effect and gets no read response.
- R7: The mode register at offset 0x20 uses these bits: 0 auth-only, 1 pad/end, 2 init, 3 partial, 4 context-unload, 5 context-reload. Writing a value that has partial, unload and pad/end all set sets status bit 2 (configuration error). So does a value that has partial, reload and init all set.
- R8: The status register at offset 0x28 is readable. Its bits stay set until a write of one to that bit clears them. `irq` is the OR of the status bits.
- R9: A pulse on `unload_start` while idle streams nine words in this order: IV 1, ICV-in, IV 2, then context registers 0 to 5. The first word is valid in the cycle after the start pulse. One word is accepted per cycle in which valid and ready are both high, and `unload_last` is high only on the ninth word.
- R10: While ready is low, the current word and its valid signal are held. A start pulse during an unload is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Host access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 20 | Byte address |
| bus_wdata | input | 64 | Write data |
| bus_rvalid | output | 1 | Read response valid (one cycle after the read) |
| bus_rdata | output | 64 | Read response data |
| engine_busy | input | 1 | Datapath is processing |
| conf_key | output | 128 | Confidentiality key |
| integ_key | output | 128 | Integrity key |
| mode_bits | output | 6 | Current mode register |
| irq | output | 1 | Any status bit set |
| ctx_iv1 | input | 64 | Saved IV 1 |
| ctx_icv_in | input | 64 | Saved ICV-in |
| ctx_iv2 | input | 64 | Saved IV 2 |
| ctx_regs | input | 384 | Six saved context words, word i at bits 64i+63:64i |
| unload_start | input | 1 | Start a context unload |
| unload_ready | input | 1 | Consumer accepts a word |
| unload_valid | output | 1 | Unload word valid |
| unload_data | output | 64 | Unload word |
| unload_last | output | 1 | Ninth word marker |

## Verification
A write that misses the busy guard, or a slot decode that is wrong, shows up on `conf_key` or `integ_key` in the cycle right after the bus write. A status bit that was set or cleared at the wrong time shows up on `irq`, and on a status read one cycle later. If the unload index is wrong, a word appears out of order or `unload_last` lands on the wrong beat on the very next handshake. A stall that lets the index move on changes `unload_data` while ready is low.

// File: rtl/ckb_pkg.sv
package ckb_pkg;
    localparam int unsigned WORD_DEF   = 64;
    localparam int unsigned ADDR_DEF   = 20;
    localparam int unsigned WIN_DEF    = 8;
    localparam logic [ADDR_DEF-1:0] BASE_DEF = 20'h3E400;

    // slot codes: bit 2 clear means a key slot
    typedef enum logic [2:0] {
        SL_CONF_HI = 3'd0,
        SL_CONF_LO = 3'd1,
        SL_INTG_HI = 3'd2,
        SL_INTG_LO = 3'd3,
        SL_MODE    = 3'd4,
        SL_STAT    = 3'd5,
        SL_HOLE    = 3'd6,
        SL_OUTSIDE = 3'd7
    } slot_e;

    typedef struct packed {
        logic  req;
        logic  wr;
        slot_e slot;
    } acc_t;

    typedef struct packed {
        logic ctx_reload;
        logic ctx_unload;
        logic partial;
        logic init;
        logic pad_end;
        logic auth_only;
    } mode_t;
    localparam int unsigned MODE_W = $bits(mode_t);

    typedef struct packed {
        logic cfg_err;
        logic ctx_err;
        logic addr_err;
    } stat_t;
    localparam int unsigned STAT_W = $bits(stat_t);

    function automatic logic mode_bad(input mode_t m);
        return (m.partial && m.ctx_unload && m.pad_end) ||
               (m.partial && m.ctx_reload && m.init);
    endfunction
endpackage

// File: rtl/ckb_decode.sv
module ckb_decode
    import ckb_pkg::*;
#(
    parameter int unsigned ADDR_W   = ADDR_DEF,
    parameter int unsigned WIN_BITS = WIN_DEF,
    parameter logic [ADDR_W-1:0] BASE = BASE_DEF
) (
    input  logic              req,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output acc_t              acc
);
    localparam int unsigned OFF_W = WIN_BITS - 3;

    logic [OFF_W-1:0] widx;
    logic             in_win;
    slot_e            slot;

    assign widx   = addr[WIN_BITS-1:3];
    assign in_win = (addr[ADDR_W-1:WIN_BITS] == BASE[ADDR_W-1:WIN_BITS]);

    always_comb begin
        if (!in_win) begin
            slot = SL_OUTSIDE;
        end else if (addr[2:0] != 3'd0) begin
            slot = SL_HOLE;
        end else begin
            case (widx)
                OFF_W'(0): slot = SL_CONF_HI;
                OFF_W'(1): slot = SL_CONF_LO;
                OFF_W'(2): slot = SL_INTG_HI;
                OFF_W'(3): slot = SL_INTG_LO;
                OFF_W'(4): slot = SL_MODE;
                OFF_W'(5): slot = SL_STAT;
                default:   slot = SL_HOLE;
            endcase
        end
    end

    assign acc = '{req: req, wr: wr, slot: slot};
endmodule

// File: rtl/ckb_key_store.sv
module ckb_key_store
    import ckb_pkg::*;
#(
    parameter int unsigned WORD_W = WORD_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  acc_t                acc,
    input  logic                busy,
    input  logic                auth_only,
    input  logic [WORD_W-1:0]   wdata,
    output logic [2*WORD_W-1:0] conf_key,
    output logic [2*WORD_W-1:0] integ_key,
    output logic                wr_rejected
);
    localparam int unsigned NSLOT = 4;

    logic [NSLOT-1:0][WORD_W-1:0] key_q;
    logic [2:0] sidx;
    logic [1:0] tgt;
    logic       key_wr;
    logic       wr_ok;

    assign sidx   = acc.slot;
    assign key_wr = acc.req && acc.wr && !sidx[2];
    assign wr_ok  = key_wr && !busy;
    assign wr_rejected = key_wr && busy;

    // authentication-only mode redirects the low pair onto the integrity pair
    always_comb begin
        tgt = sidx[1:0];
        if (auth_only && !sidx[1]) tgt = {1'b1, sidx[0]};
    end

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)                       key_q[g] <= '0;
            else if (wr_ok && tgt == 2'(g)) key_q[g] <= wdata;
        end
    end

    assign conf_key  = {key_q[0], key_q[1]};
    assign integ_key = {key_q[2], key_q[3]};

    p_busy_write_dropped_r4: assert property (@(posedge clk) disable iff (rst)
        (acc.req && acc.wr && busy) |=> $stable(key_q));

    p_alias_spares_conf_r5: assert property (@(posedge clk) disable iff (rst)
        (acc.req && acc.wr && auth_only &&
         (acc.slot == SL_CONF_HI || acc.slot == SL_CONF_LO)) |=> $stable(conf_key));
endmodule

// File: rtl/ckb_ctrl_regs.sv
module ckb_ctrl_regs
    import ckb_pkg::*;
#(
    parameter int unsigned WORD_W = WORD_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  acc_t              acc,
    input  logic [MODE_W-1:0] wdata_lo,
    input  logic              wr_rejected,
    output mode_t             mode_q,
    output stat_t             stat_q,
    output logic              rvalid,
    output logic [WORD_W-1:0] rdata,
    output logic              irq
);
    logic  is_key, is_rd, mode_wr, stat_wr;
    mode_t mode_new;
    stat_t set_v, clr_v;

    assign is_key   = (acc.slot == SL_CONF_HI) || (acc.slot == SL_CONF_LO) ||
                      (acc.slot == SL_INTG_HI) || (acc.slot == SL_INTG_LO);
    assign is_rd    = acc.req && !acc.wr && (acc.slot != SL_OUTSIDE);
    assign mode_wr  = acc.req && acc.wr && (acc.slot == SL_MODE);
    assign stat_wr  = acc.req && acc.wr && (acc.slot == SL_STAT);
    assign mode_new = mode_t'(wdata_lo);

    always_comb begin
        set_v          = '0;
        set_v.addr_err = acc.req && ((acc.slot == SL_HOLE) || (!acc.wr && is_key));
        set_v.ctx_err  = wr_rejected;
        set_v.cfg_err  = mode_wr && mode_bad(mode_new);
        clr_v          = stat_wr ? stat_t'(wdata_lo[STAT_W-1:0]) : stat_t'('0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            stat_q <= '0;
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            if (mode_wr) mode_q <= mode_new;
            stat_q <= (stat_q & ~clr_v) | set_v;
            rvalid <= is_rd;
            if (is_rd) begin
                case (acc.slot)
                    SL_MODE: rdata <= WORD_W'(mode_q);
                    SL_STAT: rdata <= WORD_W'(stat_q);
                    default: rdata <= '0;
                endcase
            end
        end
    end

    assign irq = |stat_q;

    p_key_read_blank_r3: assert property (@(posedge clk) disable iff (rst)
        (acc.req && !acc.wr && is_key) |=> (rvalid && rdata == '0 && stat_q.addr_err));

    p_addr_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (stat_q.addr_err && !stat_wr) |=> stat_q.addr_err);

    p_ctx_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (stat_q.ctx_err && !stat_wr) |=> stat_q.ctx_err);

    p_cfg_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (stat_q.cfg_err && !stat_wr) |=> stat_q.cfg_err);

    p_outside_silent_r6: assert property (@(posedge clk) disable iff (rst)
        (acc.req && acc.slot == SL_OUTSIDE) |=> !rvalid);
endmodule

// File: rtl/ckb_unload_seq.sv
module ckb_unload_seq #(
    parameter int unsigned WORD_W = 64,
    parameter int unsigned NWORDS = 9
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NWORDS-1:0][WORD_W-1:0]  words,
    input  logic                           start,
    input  logic                           ready,
    output logic                           valid,
    output logic [WORD_W-1:0]              data,
    output logic                           last
);
    localparam int unsigned IDX_W = $clog2(NWORDS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NWORDS - 1);

    typedef enum logic {ST_IDLE, ST_RUN} st_e;
    st_e             st_q;
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            idx_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (start) begin
                    st_q  <= ST_RUN;
                    idx_q <= '0;
                end
                ST_RUN: if (ready) begin
                    if (idx_q == LAST_IDX) st_q  <= ST_IDLE;
                    else                   idx_q <= idx_q + 1'b1;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign valid = (st_q == ST_RUN);
    assign data  = words[idx_q];
    assign last  = valid && (idx_q == LAST_IDX);

    p_stall_holds_r10: assert property (@(posedge clk) disable iff (rst)
        (valid && !ready) |=> (valid && $stable(idx_q)));

    p_done_after_last_r9: assert property (@(posedge clk) disable iff (rst)
        (valid && ready && last) |=> !valid);

    p_step_by_one_r9: assert property (@(posedge clk) disable iff (rst)
        (valid && ready && !last) |=> (valid && idx_q == $past(idx_q) + 1'b1));
endmodule

// File: rtl/cipher_key_bank.sv
module cipher_key_bank
    import ckb_pkg::*;
#(
    parameter int unsigned WORD_W   = WORD_DEF,
    parameter int unsigned ADDR_W   = ADDR_DEF,
    parameter int unsigned WIN_BITS = WIN_DEF,
    parameter logic [ADDR_W-1:0] BASE = BASE_DEF,
    parameter int unsigned NCTX     = 6,
    localparam int unsigned NWORDS  = NCTX + 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bus_req,
    input  logic                   bus_wr,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [WORD_W-1:0]      bus_wdata,
    output logic                   bus_rvalid,
    output logic [WORD_W-1:0]      bus_rdata,
    input  logic                   engine_busy,
    output logic [2*WORD_W-1:0]    conf_key,
    output logic [2*WORD_W-1:0]    integ_key,
    output logic [MODE_W-1:0]      mode_bits,
    output logic                   irq,
    input  logic [WORD_W-1:0]      ctx_iv1,
    input  logic [WORD_W-1:0]      ctx_icv_in,
    input  logic [WORD_W-1:0]      ctx_iv2,
    input  logic [NCTX*WORD_W-1:0] ctx_regs,
    input  logic                   unload_start,
    input  logic                   unload_ready,
    output logic                   unload_valid,
    output logic [WORD_W-1:0]      unload_data,
    output logic                   unload_last
);
    acc_t  acc;
    mode_t mode_q;
    stat_t stat_q;
    logic  wr_rejected;
    logic [NWORDS-1:0][WORD_W-1:0] words;

    ckb_decode #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .BASE(BASE)) u_dec (
        .req(bus_req), .wr(bus_wr), .addr(bus_addr), .acc(acc)
    );

    ckb_key_store #(.WORD_W(WORD_W)) u_keys (
        .clk(clk), .rst(rst), .acc(acc), .busy(engine_busy),
        .auth_only(mode_q.auth_only), .wdata(bus_wdata),
        .conf_key(conf_key), .integ_key(integ_key), .wr_rejected(wr_rejected)
    );

    ckb_ctrl_regs #(.WORD_W(WORD_W)) u_ctrl (
        .clk(clk), .rst(rst), .acc(acc), .wdata_lo(bus_wdata[MODE_W-1:0]),
        .wr_rejected(wr_rejected), .mode_q(mode_q), .stat_q(stat_q),
        .rvalid(bus_rvalid), .rdata(bus_rdata), .irq(irq)
    );

    // fixed unload order: IV 1, ICV-in, IV 2, then the context words
    assign words[0] = ctx_iv1;
    assign words[1] = ctx_icv_in;
    assign words[2] = ctx_iv2;
    for (genvar i = 0; i < NCTX; i++) begin : g_ctx
        assign words[3+i] = ctx_regs[i*WORD_W +: WORD_W];
    end

    ckb_unload_seq #(.WORD_W(WORD_W), .NWORDS(NWORDS)) u_seq (
        .clk(clk), .rst(rst), .words(words), .start(unload_start),
        .ready(unload_ready), .valid(unload_valid), .data(unload_data),
        .last(unload_last)
    );

    assign mode_bits = mode_q;

    p_irq_tracks_status_r8: assert property (@(posedge clk) disable iff (rst)
        (stat_q == '0) |-> !irq);
endmodule

// File: tb/sim_cipher_key_bank.sv
module sim_cipher_key_bank;
    localparam logic [19:0] B = 20'h3E400;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_req = 0, bus_wr = 0;
    logic [19:0] bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic bus_rvalid;
    logic [63:0] bus_rdata;
    logic engine_busy = 0;
    logic [127:0] conf_key, integ_key;
    logic [5:0] mode_bits;
    logic irq;
    logic [63:0] ctx_iv1 = 64'h1111_0000_0000_0001;
    logic [63:0] ctx_icv_in = 64'h2222_0000_0000_0002;
    logic [63:0] ctx_iv2 = 64'h3333_0000_0000_0003;
    logic [383:0] ctx_regs;
    logic unload_start = 0, unload_ready = 0;
    logic unload_valid, unload_last;
    logic [63:0] unload_data;

    int n_chk = 0, n_fail = 0;
    logic [63:0] exp_w [9];

    always #5 clk = ~clk;

    cipher_key_bank u0 (.*);

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [19:0] a, input logic [63:0] d);
        @(negedge clk);
        bus_req = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 0; bus_wr = 0;
    endtask

    task automatic bus_read(input logic [19:0] a, output logic [63:0] d, output logic v);
        @(negedge clk);
        bus_req = 1; bus_wr = 0; bus_addr = a;
        @(negedge clk);
        bus_req = 0;
        d = bus_rdata; v = bus_rvalid;
    endtask

    task automatic clear_status();
        bus_write(B + 20'h28, 64'h7);
    endtask

    task automatic t_reset();
        chk("R1 conf_key", conf_key, '0);
        chk("R1 integ_key", integ_key, '0);
        chk("R1 mode", mode_bits, '0);
        chk("R1 irq", irq, 1'b0);
        chk("R1 unload_valid", unload_valid, 1'b0);
    endtask

    task automatic t_key_load();
        bus_write(B + 20'h00, 64'hA0A1A2A3A4A5A6A7);
        chk("R2 conf hi", conf_key, {64'hA0A1A2A3A4A5A6A7, 64'h0});
        bus_write(B + 20'h08, 64'hB0B1B2B3B4B5B6B7);
        bus_write(B + 20'h10, 64'hC0C1C2C3C4C5C6C7);
        bus_write(B + 20'h18, 64'hD0D1D2D3D4D5D6D7);
        chk("R2 conf key", conf_key, {64'hA0A1A2A3A4A5A6A7, 64'hB0B1B2B3B4B5B6B7});
        chk("R2 integ key", integ_key, {64'hC0C1C2C3C4C5C6C7, 64'hD0D1D2D3D4D5D6D7});
        chk("R2 no irq", irq, 1'b0);
    endtask

    task automatic t_key_read();
        logic [63:0] d; logic v;
        bus_read(B + 20'h10, d, v);
        chk("R3 rvalid", v, 1'b1);
        chk("R3 rdata blank", d, '0);
        bus_read(B + 20'h28, d, v);
        chk("R3 addr_err bit", d, 64'h1);
        clear_status();
    endtask

    task automatic t_busy_write();
        logic [63:0] d; logic v;
        // write issued in the same cycle busy rises
        @(negedge clk);
        engine_busy = 1; bus_req = 1; bus_wr = 1; bus_addr = B + 20'h08; bus_wdata = 64'hDEAD;
        @(negedge clk);
        bus_req = 0; bus_wr = 0;
        chk("R4 conf unchanged (busy rising)", conf_key, {64'hA0A1A2A3A4A5A6A7, 64'hB0B1B2B3B4B5B6B7});
        bus_write(B + 20'h18, 64'hBEEF);
        chk("R4 integ unchanged", integ_key, {64'hC0C1C2C3C4C5C6C7, 64'hD0D1D2D3D4D5D6D7});
        engine_busy = 0;
        bus_read(B + 20'h28, d, v);
        chk("R4 ctx_err bit", d, 64'h2);
        clear_status();
        chk("R8 irq cleared", irq, 1'b0);
    endtask

    task automatic t_auth_alias();
        bus_write(B + 20'h20, 64'h1);
        chk("R5 mode auth-only", mode_bits, 6'h01);
        bus_write(B + 20'h00, 64'h0123456789ABCDEF);
        bus_write(B + 20'h08, 64'hFEDCBA9876543210);
        chk("R5 integ aliased", integ_key, {64'h0123456789ABCDEF, 64'hFEDCBA9876543210});
        chk("R5 conf untouched", conf_key, {64'hA0A1A2A3A4A5A6A7, 64'hB0B1B2B3B4B5B6B7});
        bus_write(B + 20'h20, 64'h0);
    endtask

    task automatic t_holes();
        logic [63:0] d; logic v;
        bus_write(B + 20'h30, 64'h5);
        chk("R6 hole write irq", irq, 1'b1);
        clear_status();
        bus_read(B + 20'hF8, d, v);
        chk("R6 hole read rvalid", v, 1'b1);
        chk("R6 hole read irq", irq, 1'b1);
        clear_status();
        bus_write(B + 20'h04, 64'h77);
        chk("R6 misaligned irq", irq, 1'b1);
        chk("R6 misaligned no key change", conf_key, {64'hA0A1A2A3A4A5A6A7, 64'hB0B1B2B3B4B5B6B7});
        clear_status();
        bus_write(20'h3E500, 64'h99);
        chk("R6 outside no irq", irq, 1'b0);
        chk("R6 outside no key change", conf_key, {64'hA0A1A2A3A4A5A6A7, 64'hB0B1B2B3B4B5B6B7});
        bus_read(20'h00000, d, v);
        chk("R6 outside no rvalid", v, 1'b0);
    endtask

    task automatic t_mode_check();
        logic [63:0] d; logic v;
        bus_write(B + 20'h20, 64'h1A); // partial, unload, pad/end
        bus_read(B + 20'h28, d, v);
        chk("R7 unload+pad cfg_err", d, 64'h4);
        bus_read(B + 20'h20, d, v);
        chk("R7 mode readback", d, 64'h1A);
        clear_status();
        bus_write(B + 20'h20, 64'h2C); // partial, reload, init
        chk("R7 reload+init irq", irq, 1'b1);
        clear_status();
        bus_write(B + 20'h20, 64'h1C); // partial, unload, init: legal
        chk("R7 legal mode no irq", irq, 1'b0);
        bus_write(B + 20'h20, 64'h0);
    endtask

    task automatic t_w1c();
        logic [63:0] d; logic v;
        bus_write(B + 20'h40, 64'h0);           // addr_err
        @(negedge clk); engine_busy = 1;
        bus_write(B + 20'h00, 64'h1);           // ctx_err
        engine_busy = 0;
        bus_write(B + 20'h28, 64'h1);           // clear only addr_err
        bus_read(B + 20'h28, d, v);
        chk("R8 partial clear", d, 64'h2);
        repeat (3) @(negedge clk);
        chk("R8 sticky irq", irq, 1'b1);
        clear_status();
        chk("R8 fully cleared", irq, 1'b0);
    endtask

    task automatic t_unload();
        @(negedge clk);
        unload_ready = 1; unload_start = 1;
        @(negedge clk);
        unload_start = 0;
        for (int k = 0; k < 9; k++) begin
            chk($sformatf("R9 valid word %0d", k), unload_valid, 1'b1);
            chk($sformatf("R9 data word %0d", k), unload_data, exp_w[k]);
            chk($sformatf("R9 last word %0d", k), unload_last, (k == 8));
            @(negedge clk);
        end
        chk("R9 idle after last", unload_valid, 1'b0);
    endtask

    task automatic t_unload_stall();
        @(negedge clk);
        unload_ready = 0; unload_start = 1;
        @(negedge clk);
        unload_start = 0;
        repeat (3) @(negedge clk);
        chk("R10 held valid", unload_valid, 1'b1);
        chk("R10 held word", unload_data, exp_w[0]);
        unload_ready = 1;
        @(negedge clk);
        unload_start = 1;                        // ignored mid-stream
        chk("R10 advance", unload_data, exp_w[1]);
        @(negedge clk);
        unload_start = 0;
        chk("R10 start ignored", unload_data, exp_w[2]);
        repeat (6) @(negedge clk);
        chk("R10 last in order", unload_last, 1'b1);
        chk("R10 last data", unload_data, exp_w[8]);
        @(negedge clk);
        chk("R10 done", unload_valid, 1'b0);
        unload_ready = 0;
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog act=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 6; i++) ctx_regs[i*64 +: 64] = 64'hC7C7_0000_0000_0000 | 64'(i + 16);
        exp_w[0] = ctx_iv1; exp_w[1] = ctx_icv_in; exp_w[2] = ctx_iv2;
        for (int i = 0; i < 6; i++) exp_w[3+i] = 64'hC7C7_0000_0000_0000 | 64'(i + 16);
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_key_load();
        t_key_read();
        t_busy_write();
        t_auth_alias();
        t_holes();
        t_mode_check();
        t_w1c();
        t_unload();
        t_unload_stall();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule